// File: doc/BRIEF.md
# Display Protection Monitor

This block supervises the scan stages of a display and turns their state into two controls: a blank request for the RGB outputs and an enable for the horizontal drive. Two checks feed those controls. The first is a field watchdog. It expects the vertical flyback input to fall at least once between two field strobes, and it raises blanking when a field closes without such a fall. The second is a supervisor for a digitised safety voltage. It sorts that voltage into one of three zones using two programmable thresholds, and each threshold has its own programmable hysteresis.

The flyback input is asynchronous, so it passes through a synchroniser before its edges are examined. Software can turn the watchdog on or off with an enable bit. The safety supervisor is always active. Its normal zone is also the reset state, so the horizontal drive is enabled from power-up, even while reset is held.

Top module: `dispProtMon`

## Requirements
- R1: While reset is asserted, and after it is released with a safety level at or below the lower threshold, `rgbBlank` is 0 and `hDriveEn` is 1.
- R2: With the watchdog enabled, a field in which the flyback input falls from 1 to 0 leaves `rgbBlank` at 0 after the field strobe.
- R3: With the watchdog enabled, a field with no falling flyback edge sets `rgbBlank` to 1 from the cycle after the strobe, and it stays 1 until a later strobe.
- R4: Watchdog blanking is cleared at the strobe that closes the next field with a falling flyback edge.
- R5: With `wdogEnable` at 0 the watchdog never causes blanking. A watchdog fault that is already latched is masked at once.
- R6: A safety level at or below `lowThr`, starting from the normal zone, gives `rgbBlank`=0 and `hDriveEn`=1.
- R7: A level above `lowThr` and at or below `highThr` gives `rgbBlank`=1 and `hDriveEn`=1.
- R8: A level above `highThr` gives `rgbBlank`=1 and `hDriveEn`=0. This zone is reached directly from any zone.
- R9: The middle zone is left for the normal zone only when the level drops below `lowThr - lowHyst`. A level equal to that release point keeps blanking.
- R10: The upper zone is left only when the level drops below `highThr - highHyst`. It then goes to the normal zone if the level is also below `lowThr - lowHyst`, and to the middle zone otherwise.
- R11: `rgbBlank` is the OR of the watchdog fault and a non-normal safety zone. `hDriveEn` depends only on the safety zone.
- R12: Only a 1-to-0 transition of the flyback input counts as an edge. A field that shows only a rise, or that stays high, is a missed field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fieldStrobe | input | 1 | One-cycle pulse that closes a field |
| flybackIn | input | 1 | Asynchronous vertical flyback signal |
| wdogEnable | input | 1 | Enables the flyback watchdog |
| safetyLevel | input | LEVEL_W | Digitised safety voltage |
| lowThr | input | LEVEL_W | Lower (blank) threshold |
| lowHyst | input | LEVEL_W | Hysteresis of the lower threshold |
| highThr | input | LEVEL_W | Upper (drive-off) threshold |
| highHyst | input | LEVEL_W | Hysteresis of the upper threshold |
| rgbBlank | output | 1 | Blank request for the RGB outputs |
| hDriveEn | output | 1 | Horizontal drive enable |

## Verification
A corrupted safety zone appears at the ports as a wrong blank or drive-enable value two clock edges after the level changes. Holding the level at each release point shows whether hysteresis is missing or off by one, because the outputs then flip one step early. A wrong edge latch or fault register shows up only at the next field strobe, so each watchdog check samples one cycle after that strobe. Mid-field checks confirm that blanking does not leak out between strobes.

// File: rtl/dpmPkg.sv
package dpmPkg;

  typedef enum logic [1:0] {
    ZONE_OK    = 2'd0,
    ZONE_BLANK = 2'd1,
    ZONE_KILL  = 2'd2
  } zone_e;

  typedef struct packed {
    logic fallThisField;
    logic aboveLow;
    logic aboveHigh;
    logic belowLowRel;
    logic belowHighRel;
  } dpFlags_t;

  typedef struct packed {
    logic clearEdge;
  } ctlStrobes_t;

endpackage

// File: rtl/dpmDatapath.sv
module dpmDatapath #(
  parameter int LEVEL_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  flybackIn,
  input  logic [LEVEL_W-1:0]    safetyLevel,
  input  logic [LEVEL_W-1:0]    lowThr,
  input  logic [LEVEL_W-1:0]    lowHyst,
  input  logic [LEVEL_W-1:0]    highThr,
  input  logic [LEVEL_W-1:0]    highHyst,
  input  dpmPkg::ctlStrobes_t   strobes,
  output dpmPkg::dpFlags_t      flags
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   flyPrev;
  logic                   fallNow;
  logic                   edgeSeen;
  logic [LEVEL_W-1:0]     lowRel;
  logic [LEVEL_W-1:0]     highRel;
  logic                   aboveLowQ, aboveHighQ, belowLowRelQ, belowHighRelQ;

  // Synchroniser chain, one flop per stage.
  for (genvar i = 0; i < SYNC_STAGES; i++) begin : gSync
    if (i == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ[i] <= 1'b0;
        else       syncQ[i] <= flybackIn;
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ[i] <= 1'b0;
        else       syncQ[i] <= syncQ[i-1];
    end
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) flyPrev <= 1'b0;
    else       flyPrev <= syncQ[LAST];

  assign fallNow = flyPrev & ~syncQ[LAST];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                  edgeSeen <= 1'b0;
    else if (strobes.clearEdge) edgeSeen <= 1'b0;
    else if (fallNow)           edgeSeen <= 1'b1;

  // Release points, saturating at zero.
  always_comb begin
    lowRel  = (lowThr  >= lowHyst)  ? lowThr  - lowHyst  : '0;
    highRel = (highThr >= highHyst) ? highThr - highHyst : '0;
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      aboveLowQ     <= 1'b0;
      aboveHighQ    <= 1'b0;
      belowLowRelQ  <= 1'b1;
      belowHighRelQ <= 1'b1;
    end else begin
      aboveLowQ     <= safetyLevel > lowThr;
      aboveHighQ    <= safetyLevel > highThr;
      belowLowRelQ  <= safetyLevel < lowRel;
      belowHighRelQ <= safetyLevel < highRel;
    end

  always_comb begin
    flags.fallThisField = edgeSeen | fallNow;
    flags.aboveLow      = aboveLowQ;
    flags.aboveHigh     = aboveHighQ;
    flags.belowLowRel   = belowLowRelQ;
    flags.belowHighRel  = belowHighRelQ;
  end

endmodule

// File: rtl/dpmControl.sv
module dpmControl (
  input  logic                clk,
  input  logic                rstN,
  input  logic                fieldStrobe,
  input  logic                wdogEnable,
  input  dpmPkg::dpFlags_t    flags,
  output dpmPkg::ctlStrobes_t strobes,
  output dpmPkg::zone_e       zoneQ,
  output logic                wdogFault,
  output logic                rgbBlank,
  output logic                hDriveEn
);
  import dpmPkg::*;

  zone_e zoneNext;

  always_comb begin
    zoneNext = zoneQ;
    unique case (zoneQ)
      ZONE_OK: begin
        if (flags.aboveHigh)     zoneNext = ZONE_KILL;
        else if (flags.aboveLow) zoneNext = ZONE_BLANK;
      end
      ZONE_BLANK: begin
        if (flags.aboveHigh)        zoneNext = ZONE_KILL;
        else if (flags.belowLowRel) zoneNext = ZONE_OK;
      end
      ZONE_KILL: begin
        if (flags.belowHighRel)
          zoneNext = flags.belowLowRel ? ZONE_OK : ZONE_BLANK;
      end
      default: zoneNext = ZONE_OK;
    endcase
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) zoneQ <= ZONE_OK;
    else       zoneQ <= zoneNext;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)            wdogFault <= 1'b0;
    else if (fieldStrobe) wdogFault <= wdogEnable & ~flags.fallThisField;

  always_comb begin
    strobes.clearEdge = fieldStrobe;
    rgbBlank = (wdogFault & wdogEnable) | (zoneQ != ZONE_OK);
    hDriveEn = (zoneQ != ZONE_KILL);
  end

endmodule

// File: rtl/dispProtMon.sv
module dispProtMon #(
  parameter int LEVEL_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fieldStrobe,
  input  logic               flybackIn,
  input  logic               wdogEnable,
  input  logic [LEVEL_W-1:0] safetyLevel,
  input  logic [LEVEL_W-1:0] lowThr,
  input  logic [LEVEL_W-1:0] lowHyst,
  input  logic [LEVEL_W-1:0] highThr,
  input  logic [LEVEL_W-1:0] highHyst,
  output logic               rgbBlank,
  output logic               hDriveEn
);

  dpmPkg::dpFlags_t    flags;
  dpmPkg::ctlStrobes_t strobes;
  dpmPkg::zone_e       zoneQ;
  logic                wdogFault;

  dpmDatapath #(.LEVEL_W(LEVEL_W), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rstN(rstN), .flybackIn(flybackIn),
    .safetyLevel(safetyLevel), .lowThr(lowThr), .lowHyst(lowHyst),
    .highThr(highThr), .highHyst(highHyst),
    .strobes(strobes), .flags(flags)
  );

  dpmControl uCtl (
    .clk(clk), .rstN(rstN), .fieldStrobe(fieldStrobe),
    .wdogEnable(wdogEnable), .flags(flags), .strobes(strobes),
    .zoneQ(zoneQ), .wdogFault(wdogFault),
    .rgbBlank(rgbBlank), .hDriveEn(hDriveEn)
  );

endmodule

// File: rtl/dpmChecker.sv
module dpmChecker (
  input logic             clk,
  input logic             rstN,
  input logic             fieldStrobe,
  input logic             wdogEnable,
  input logic             rgbBlank,
  input logic             hDriveEn,
  input dpmPkg::zone_e    zone,
  input logic             wdogFault,
  input dpmPkg::dpFlags_t flags
);
  import dpmPkg::*;

  a_r8_drive_off_blanks: assert property (@(posedge clk) disable iff (!rstN)
    !hDriveEn |-> rgbBlank);

  a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!wdogEnable && zone == ZONE_OK) |-> !rgbBlank);

  a_r3_fault_on_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdogFault) |-> $past(fieldStrobe));

  a_r3_missed_field: assert property (@(posedge clk) disable iff (!rstN)
    (fieldStrobe && wdogEnable && !flags.fallThisField) |=> wdogFault);

  a_r7_blank_entry: assert property (@(posedge clk) disable iff (!rstN)
    (zone == ZONE_BLANK && $past(zone) == ZONE_OK) |-> $past(flags.aboveLow));

  a_r8_kill_entry: assert property (@(posedge clk) disable iff (!rstN)
    (zone == ZONE_KILL && $past(zone) != ZONE_KILL) |-> $past(flags.aboveHigh));

  a_r9_low_release: assert property (@(posedge clk) disable iff (!rstN)
    (zone == ZONE_OK && $past(zone) == ZONE_BLANK) |-> $past(flags.belowLowRel));

  a_r10_high_release: assert property (@(posedge clk) disable iff (!rstN)
    (zone != ZONE_KILL && $past(zone) == ZONE_KILL) |-> $past(flags.belowHighRel));

endmodule

bind dispProtMon dpmChecker uChk (
  .clk(clk), .rstN(rstN), .fieldStrobe(fieldStrobe), .wdogEnable(wdogEnable),
  .rgbBlank(rgbBlank), .hDriveEn(hDriveEn), .zone(zoneQ),
  .wdogFault(wdogFault), .flags(flags)
);

// File: tb/tb_dispProtMon.sv
module tb_dispProtMon;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fieldStrobe = 1'b0;
  logic flybackIn = 1'b0;
  logic wdogEnable = 1'b0;
  logic [7:0] safetyLevel = 8'd0;
  logic [7:0] lowThr = 8'd100, lowHyst = 8'd10, highThr = 8'd180, highHyst = 8'd20;
  logic rgbBlank, hDriveEn;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dispProtMon dut (
    .clk(clk), .rstN(rstN), .fieldStrobe(fieldStrobe), .flybackIn(flybackIn),
    .wdogEnable(wdogEnable), .safetyLevel(safetyLevel), .lowThr(lowThr),
    .lowHyst(lowHyst), .highThr(highThr), .highHyst(highHyst),
    .rgbBlank(rgbBlank), .hDriveEn(hDriveEn)
  );

  // {level, expected blank, expected drive enable}; release points 90 and 160
  localparam bit [9:0] SAFETY_VEC [16] = '{
    {8'd50, 1'b0, 1'b1}, {8'd100, 1'b0, 1'b1}, {8'd101, 1'b1, 1'b1},
    {8'd95, 1'b1, 1'b1}, {8'd90, 1'b1, 1'b1},  {8'd89, 1'b0, 1'b1},
    {8'd150, 1'b1, 1'b1}, {8'd180, 1'b1, 1'b1}, {8'd181, 1'b1, 1'b0},
    {8'd165, 1'b1, 1'b0}, {8'd160, 1'b1, 1'b0}, {8'd159, 1'b1, 1'b1},
    {8'd120, 1'b1, 1'b1}, {8'd200, 1'b1, 1'b0}, {8'd50, 1'b0, 1'b1},
    {8'd250, 1'b1, 1'b0}
  };

  task automatic check(input string req, input logic eb, input logic ed);
    total++;
    if (rgbBlank !== eb || hDriveEn !== ed) begin
      bad++;
      $display("FAIL %s: blank=%0b exp %0b, hdrive=%0b exp %0b",
               req, rgbBlank, eb, hDriveEn, ed);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setLevel(input logic [7:0] lv);
    safetyLevel = lv;
    ticks(3);
  endtask

  // withFall: high then low inside the field; otherwise the line is left as is
  task automatic runField(input bit withFall);
    if (withFall) begin
      flybackIn = 1'b1; ticks(4);
      flybackIn = 1'b0; ticks(4);
    end else ticks(8);
    fieldStrobe = 1'b1;
    @(negedge clk);
    fieldStrobe = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    ticks(3);
    check("R1 in reset", 1'b0, 1'b1);
    rstN = 1'b1;
    ticks(3);
    check("R1 after release", 1'b0, 1'b1);

    // Safety zones walked from the table
    for (int i = 0; i < 16; i++) begin
      setLevel(SAFETY_VEC[i][9:2]);
      check($sformatf("R6/R7/R8/R9/R10 vec %0d level %0d", i, SAFETY_VEC[i][9:2]),
            SAFETY_VEC[i][1], SAFETY_VEC[i][0]);
    end

    // Reset from the upper zone: drive enabled at once
    @(negedge clk); rstN = 1'b0; #1;
    check("R1 reset from kill", 1'b0, 1'b1);
    safetyLevel = 8'd0;
    ticks(2); rstN = 1'b1; ticks(3);
    check("R1 post reset", 1'b0, 1'b1);

    // Watchdog
    wdogEnable = 1'b1;
    runField(1'b1);
    check("R2 field with edge", 1'b0, 1'b1);
    runField(1'b0);
    check("R3 missed field", 1'b1, 1'b1);
    ticks(5);
    check("R3 held mid-field", 1'b1, 1'b1);
    runField(1'b1);
    check("R4 cleared by good field", 1'b0, 1'b1);
    flybackIn = 1'b1;
    runField(1'b0);
    check("R12 rise only", 1'b1, 1'b1);
    runField(1'b0);
    check("R12 stuck high", 1'b1, 1'b1);
    runField(1'b1);
    check("R4 recovery", 1'b0, 1'b1);

    // OR of the two sources
    runField(1'b0);
    setLevel(8'd150);
    check("R11 fault plus middle zone", 1'b1, 1'b1);
    setLevel(8'd250);
    check("R11 fault plus upper zone", 1'b1, 1'b0);
    setLevel(8'd0);
    check("R11 fault alone, drive on", 1'b1, 1'b1);

    // Disabled watchdog masks a latched fault and does not raise new ones
    wdogEnable = 1'b0; #1;
    check("R5 latched fault masked", 1'b0, 1'b1);
    ticks(1);
    runField(1'b0);
    check("R5 missed field ignored", 1'b0, 1'b1);
    runField(1'b0);
    check("R5 second missed field", 1'b0, 1'b1);
    wdogEnable = 1'b1;
    runField(1'b1);
    check("R2 re-enabled good field", 1'b0, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule